// File: doc/BRIEF.md
# PFC Start-Up and Fault Supervisor

This block sequences the start-up of a boost power-factor stage and removes gate drive on faults. It does not see analog levels. It receives digitized monitor codes for the bias supply, the output-sense divider, the voltage-error amplifier output, the soft-start pin and the die temperature. All voltage codes use 10 mV per LSB, and temperature codes use 1 °C per LSB. From these codes it produces the following outputs:

- a reference enable;
- a core enable for the oscillator and multiplier;
- a digital soft-start reference;
- a registered gate-enable;
- a clear request for the current-amplifier outputs;
- a transient-boost request for the voltage loop.

Start-up follows a fixed order. The block first waits for bias permission. It then waits until the output has pre-charged and the error amplifier reports zero power. Soft start then begins. It loads the reference in one step to the present output-sense code, then ramps it one LSB every `RAMP_DIV` cycles up to the regulation code. Each protection compares against a pair of thresholds with hysteresis. Losing bias permission, losing the enable level, or a thermal trip sends the sequencer back to idle and zeroes the reference.

Top module: `pfc_supervisor`

## Requirements
- R1: `ref_on` is 1 exactly when the bias code exceeds 800 (8.00 V). It updates one clock edge after the input changes.
- R2: Bias permission sets when the bias code exceeds 1020 and clears only when the code falls below 920. While the bias code is between these two values, permission keeps its previous state.
- R3: `core_on` stays 0 until both conditions hold: the output-sense code is at least 75 and the error-amplifier code is below 75. Once both hold, `core_on` rises two edges after the error-amplifier code drops below 75.
- R4: On the first soft-start cycle, `ss_ref` is loaded with the output-sense code, limited to the regulation code 300.
- R5: After the load, `ss_ref` rises by exactly 1 every `RAMP_DIV` cycles. It stops at 300, and the sequencer then enters the run state.
- R6: A soft-start pin code below 60 forces `gate_on` to 0. `gate_on` returns to 1 when the code is 60 or more and no other fault is present.
- R7: Over-voltage sets when the output-sense code exceeds 318 and clears when the code falls below 308. While it is set, `gate_on` is 0 and `amp_clr` is 1.
- R8: Zero power sets when the error-amplifier code falls below 75 and clears only when the code reaches 90. While it is set, `gate_on` is 0.
- R9: A die temperature code above 160 shuts the core down. Once the code falls below 140, the block restarts from the hold state with a fresh soft start.
- R10: `boost_req` is 1 when the output-sense code is below 279, but only in the run state. It is 0 throughout soft start.
- R11: `gate_on` is a register equal to the AND of five conditions: an active core, no over-voltage, no zero power, no external disable and no shutdown cause. It changes two edges after the input that caused the change.
- R12: Loss of bias permission, an output-sense code below 75, or a thermal trip returns the sequencer to idle. On the next edge, `core_on` is 0 and `ss_ref` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bias_code | input | VW | Bias supply code, 10 mV/LSB |
| osns_code | input | VW | Output-sense code, 10 mV/LSB |
| eamp_code | input | VW | Voltage-error amplifier output code |
| sspin_code | input | VW | Soft-start pin code |
| temp_code | input | TW | Die temperature code, °C |
| ref_on | output | 1 | Reference enable |
| core_on | output | 1 | Oscillator and multiplier enable |
| ss_ref | output | VW | Soft-start reference code |
| gate_on | output | 1 | Gate drive permission |
| amp_clr | output | 1 | Current-amplifier output clear |
| boost_req | output | 1 | Transient-boost request |

## Verification
The block has a two-stage latency structure.

- **One edge:** all monitor codes are compared and registered at the first clock edge, so `ref_on` follows its input after one edge.
- **Two edges:** the sequencer state, and therefore `core_on` and the jump or zeroing of `ss_ref`, changes at the following edge. `gate_on`, `amp_clr` and `boost_req` are also re-registered from the flags at that edge, so they follow after two edges.
- **Soft-start load:** the reference load happens one edge after `core_on` rises.
- **Ramp steps:** each ramp step lands `RAMP_DIV` edges after the previous one.

Every directed task drives its inputs on a falling edge and then waits exactly that many rising edges. It samples on the next falling edge. A hysteresis check holds the code inside the band for more edges than the latency before sampling.

// File: rtl/pfcsup_pkg.sv
package pfcsup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_JUMP = 3'd2,
    ST_RAMP = 3'd3,
    ST_RUN  = 3'd4
  } sup_state_t;

  // Hysteresis update: set wins over clear, otherwise hold.
  function automatic logic hyst_next(input logic cur, input logic set_c, input logic clr_c);
    if (set_c)      return 1'b1;
    else if (clr_c) return 1'b0;
    else            return cur;
  endfunction

  // States in which oscillator and multiplier run.
  function automatic logic core_active(input sup_state_t s);
    return (s == ST_JUMP) || (s == ST_RAMP) || (s == ST_RUN);
  endfunction

  // States that belong to the soft-start phase.
  function automatic logic soft_phase(input sup_state_t s);
    return (s == ST_JUMP) || (s == ST_RAMP);
  endfunction

endpackage

// File: rtl/pfcsup_hyst.sv
module pfcsup_hyst #(
  parameter int unsigned W         = 12,
  parameter int unsigned SET_ABOVE = 100,
  parameter int unsigned CLR_BELOW = 90,
  parameter bit          RST_VAL   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  output logic         flag
);
  import pfcsup_pkg::*;

  localparam logic [W-1:0] SET_C = W'(SET_ABOVE);
  localparam logic [W-1:0] CLR_C = W'(CLR_BELOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= RST_VAL;
    else        flag <= hyst_next(flag, code > SET_C, code < CLR_C);
  end
endmodule

// File: rtl/pfcsup_ramp.sv
module pfcsup_ramp #(
  parameter int unsigned VW       = 12,
  parameter int unsigned REG_CODE = 300,
  parameter int unsigned RAMP_DIV = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [VW-1:0] load_val,
  input  logic          ramping,
  output logic [VW-1:0] ref_q,
  output logic          at_top
);
  localparam int unsigned CW = (RAMP_DIV < 2) ? 1 : $clog2(RAMP_DIV);
  localparam logic [VW-1:0] TOP  = VW'(REG_CODE);
  localparam logic [CW-1:0] LAST = CW'(RAMP_DIV - 1);

  logic [CW-1:0] cnt;
  logic [VW-1:0] jump_val;
  logic          tick;

  assign jump_val = (load_val > TOP) ? TOP : load_val;
  assign tick     = (cnt == LAST);
  assign at_top   = (ref_q >= TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      cnt   <= '0;
    end else if (clr) begin
      ref_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      ref_q <= jump_val;
      cnt   <= '0;
    end else if (ramping && !at_top) begin
      if (tick) begin
        ref_q <= ref_q + 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfcsup_seq.sv
module pfcsup_seq (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   kill,
  input  logic                   ea_low,
  input  logic                   at_top,
  output pfcsup_pkg::sup_state_t state,
  output logic                   load,
  output logic                   ramping
);
  import pfcsup_pkg::*;

  sup_state_t nxt;

  always_comb begin
    nxt = state;
    if (kill) nxt = ST_IDLE;
    else begin
      case (state)
        ST_IDLE: nxt = ST_HOLD;
        ST_HOLD: if (ea_low) nxt = ST_JUMP;
        ST_JUMP: nxt = ST_RAMP;
        ST_RAMP: if (at_top) nxt = ST_RUN;
        ST_RUN:  nxt = ST_RUN;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign load    = (state == ST_JUMP) && !kill;
  assign ramping = (state == ST_RAMP);
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor #(
  parameter int unsigned VW        = 12,
  parameter int unsigned TW        = 8,
  parameter int unsigned RAMP_DIV  = 1000,
  parameter int unsigned REF_ON_TH = 800,
  parameter int unsigned UV_SET    = 1020,
  parameter int unsigned UV_CLR    = 920,
  parameter int unsigned EN_TH     = 75,
  parameter int unsigned ZP_CLR    = 75,
  parameter int unsigned ZP_SET    = 90,
  parameter int unsigned SSDIS_TH  = 60,
  parameter int unsigned OV_SET    = 318,
  parameter int unsigned OV_CLR    = 308,
  parameter int unsigned BOOST_TH  = 279,
  parameter int unsigned REG_CODE  = 300,
  parameter int unsigned TSD_SET   = 160,
  parameter int unsigned TSD_CLR   = 140
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] bias_code,
  input  logic [VW-1:0] osns_code,
  input  logic [VW-1:0] eamp_code,
  input  logic [VW-1:0] sspin_code,
  input  logic [TW-1:0] temp_code,
  output logic          ref_on,
  output logic          core_on,
  output logic [VW-1:0] ss_ref,
  output logic          gate_on,
  output logic          amp_clr,
  output logic          boost_req
);
  import pfcsup_pkg::*;

  localparam logic [VW-1:0] REF_ON_C = VW'(REF_ON_TH);
  localparam logic [VW-1:0] EN_C     = VW'(EN_TH);
  localparam logic [VW-1:0] ZPC_C    = VW'(ZP_CLR);
  localparam logic [VW-1:0] SSDIS_C  = VW'(SSDIS_TH);
  localparam logic [VW-1:0] BOOST_C  = VW'(BOOST_TH);

  // Named internal events, observed by the bound checker.
  logic       uvlo_ok, tsd_f, ov_f, ea_act, zp_f;
  logic       en_ok, ea_low, ext_dis, os_low, kill;
  logic       load, ramping, at_top;
  sup_state_t state;

  pfcsup_hyst #(.W(VW), .SET_ABOVE(UV_SET), .CLR_BELOW(UV_CLR)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .code(bias_code), .flag(uvlo_ok));
  pfcsup_hyst #(.W(VW), .SET_ABOVE(OV_SET), .CLR_BELOW(OV_CLR)) u_ov (
    .clk(clk), .rst_n(rst_n), .code(osns_code), .flag(ov_f));
  pfcsup_hyst #(.W(VW), .SET_ABOVE(ZP_SET - 1), .CLR_BELOW(ZP_CLR)) u_zp (
    .clk(clk), .rst_n(rst_n), .code(eamp_code), .flag(ea_act));
  pfcsup_hyst #(.W(TW), .SET_ABOVE(TSD_SET), .CLR_BELOW(TSD_CLR)) u_tsd (
    .clk(clk), .rst_n(rst_n), .code(temp_code), .flag(tsd_f));

  assign zp_f = !ea_act;
  assign kill = !uvlo_ok || tsd_f || !en_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_on  <= 1'b0;
      en_ok   <= 1'b0;
      ea_low  <= 1'b0;
      ext_dis <= 1'b0;
      os_low  <= 1'b0;
    end else begin
      ref_on  <= bias_code > REF_ON_C;
      en_ok   <= osns_code >= EN_C;
      ea_low  <= eamp_code < ZPC_C;
      ext_dis <= sspin_code < SSDIS_C;
      os_low  <= osns_code < BOOST_C;
    end
  end

  pfcsup_seq u_seq (
    .clk(clk), .rst_n(rst_n), .kill(kill), .ea_low(ea_low),
    .at_top(at_top), .state(state), .load(load), .ramping(ramping));

  pfcsup_ramp #(.VW(VW), .REG_CODE(REG_CODE), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(kill), .load(load), .load_val(osns_code),
    .ramping(ramping), .ref_q(ss_ref), .at_top(at_top));

  assign core_on = core_active(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_on   <= 1'b0;
      amp_clr   <= 1'b0;
      boost_req <= 1'b0;
    end else begin
      gate_on   <= core_active(state) && !kill && !ov_f && !zp_f && !ext_dis && !tsd_f;
      amp_clr   <= ov_f;
      boost_req <= (state == ST_RUN) && os_low;
    end
  end
endmodule

// File: rtl/pfc_supervisor_chk.sv
module pfc_supervisor_chk #(
  parameter int unsigned VW       = 12,
  parameter int unsigned REG_CODE = 300
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gate_on,
  input logic                   core_on,
  input logic                   amp_clr,
  input logic                   boost_req,
  input logic [VW-1:0]          ss_ref,
  input logic                   ov_f,
  input logic                   zp_f,
  input logic                   ext_dis,
  input logic                   kill,
  input logic                   ea_low,
  input pfcsup_pkg::sup_state_t state
);
  import pfcsup_pkg::*;

  // R11: the gate never runs without an active core
  p_gate_needs_core_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> core_on);

  // R7: over-voltage removes the gate and clears the amplifiers
  p_ov_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ov_f) |-> (!gate_on && amp_clr));

  // R8: zero power blanks the gate
  p_zp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> !$past(zp_f));

  // R6: external disable blanks the gate
  p_ext_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> !$past(ext_dis));

  // R3: the core only starts after the zero-power hold-off clears
  p_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_on) |-> $past(ea_low));

  // R5: the reference never passes regulation and moves by at most 1 per cycle
  p_ref_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_ref <= VW'(REG_CODE));
  p_ramp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_RAMP && state == ST_RAMP) |->
      (ss_ref == $past(ss_ref) || ss_ref == $past(ss_ref) + 1'b1));

  // R10: no boost request during soft start
  p_no_boost_ss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    boost_req |-> !soft_phase(state));

  // R12: a kill leaves the sequencer idle with the reference cleared
  p_kill_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kill) |-> (!core_on && ss_ref == '0));
endmodule

bind pfc_supervisor pfc_supervisor_chk #(.VW(VW), .REG_CODE(REG_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .core_on(core_on),
  .amp_clr(amp_clr), .boost_req(boost_req), .ss_ref(ss_ref), .ov_f(ov_f),
  .zp_f(zp_f), .ext_dis(ext_dis), .kill(kill), .ea_low(ea_low), .state(state));

// File: tb/pfc_supervisor_test.sv
`timescale 1ns/1ps
module pfc_supervisor_test;
  localparam int VW = 12;
  localparam int TW = 8;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] bias, osns, eamp, sspin;
  logic [TW-1:0] temp;
  logic ref_on, core_on, gate_on, amp_clr, boost_req;
  logic [VW-1:0] ss_ref;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pfc_supervisor #(.VW(VW), .TW(TW), .RAMP_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .bias_code(bias), .osns_code(osns),
    .eamp_code(eamp), .sspin_code(sspin), .temp_code(temp),
    .ref_on(ref_on), .core_on(core_on), .ss_ref(ss_ref),
    .gate_on(gate_on), .amp_clr(amp_clr), .boost_req(boost_req));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset_and_hold;
    bias = 1200; osns = 200; eamp = 200; sspin = 300; temp = 25;
    rst_n = 1'b0;
    step(3);
    chk("R11 reset gate", gate_on, 0);
    chk("R12 reset ss_ref", ss_ref, 0);
    chk("R1 reset ref_on", ref_on, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 ref_on above 8V", ref_on, 1);
    step(10);
    chk("R3 held while error amp high", core_on, 0);
    eamp = 50;
    step(2);
    chk("R3 core starts after zero power", core_on, 1);
    step(1);
    chk("R4 jump to output sense", ss_ref, 200);
  endtask

  task automatic t_ramp_and_zero_power;
    step(8);
    chk("R5 ramp two steps", ss_ref, 202);
    chk("R8 gate off in zero power", gate_on, 0);
    eamp = 80;
    step(3);
    chk("R8 hysteresis keeps gate off", gate_on, 0);
    eamp = 95;
    step(2);
    chk("R11 gate on during ramp", gate_on, 1);
    chk("R10 boost forced off in soft start", boost_req, 0);
    for (int i = 0; i < 2000; i++) begin
      if (ss_ref == 300) break;
      step(1);
    end
    chk("R5 ramp reaches regulation", ss_ref, 300);
    step(2);
    chk("R10 boost in run with low sense", boost_req, 1);
    osns = 290;
    step(2);
    chk("R10 boost drops above 2.79V", boost_req, 0);
  endtask

  task automatic t_ext_disable;
    sspin = 50;
    step(2);
    chk("R6 external pulldown gate off", gate_on, 0);
    sspin = 300;
    step(2);
    chk("R6 release resumes", gate_on, 1);
  endtask

  task automatic t_overvoltage;
    osns = 320;
    step(2);
    chk("R7 OV gate off", gate_on, 0);
    chk("R7 OV amp clear", amp_clr, 1);
    osns = 310;
    step(2);
    chk("R7 OV hysteresis gate", gate_on, 0);
    chk("R7 OV hysteresis clear", amp_clr, 1);
    osns = 300;
    step(2);
    chk("R7 OV recovered gate", gate_on, 1);
    chk("R7 OV recovered clear", amp_clr, 0);
  endtask

  task automatic t_thermal;
    temp = 170;
    step(2);
    chk("R9 thermal core off", core_on, 0);
    chk("R12 thermal ss_ref zero", ss_ref, 0);
    chk("R11 thermal gate off", gate_on, 0);
    temp = 150;
    step(5);
    chk("R9 thermal hysteresis", core_on, 0);
    temp = 130;
    step(5);
    chk("R9 restart waits for zero power", core_on, 0);
    eamp = 50;
    step(3);
    chk("R9 fresh soft start core", core_on, 1);
    chk("R4 fresh jump value", ss_ref, 300);
    eamp = 95;
    step(2);
    chk("R9 gate back after restart", gate_on, 1);
  endtask

  task automatic t_uvlo;
    bias = 950;
    step(3);
    chk("R2 inside band keeps permission", core_on, 1);
    bias = 900;
    step(2);
    chk("R12 UVLO core off", core_on, 0);
    chk("R12 UVLO ss_ref zero", ss_ref, 0);
    bias = 1000;
    step(4);
    chk("R2 below set threshold stays off", core_on, 0);
    chk("R1 ref_on at 10V", ref_on, 1);
    bias = 700;
    step(1);
    chk("R1 ref_on off below 8V", ref_on, 0);
  endtask

  initial begin
    t_reset_and_hold;
    t_ramp_and_zero_power;
    t_ext_disable;
    t_overvoltage;
    t_thermal;
    t_uvlo;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule